// File: doc/BRIEF.md
# Legacy System Control Register Bank

This block is a byte-wide bank of I/O ports for a single-board computer. A host drives a port address together with a write strobe or a read strobe. The block decodes a handful of addresses and acts on them in three ways. Some ports hold sticky control bits: the byte-order mode, the disk activity light, a 4-bit system control field and an I/O map mode bit. Some return fixed identity and status bytes. The rest turn a write into a one-cycle pulse, which asks for a soft reset, toggles one of two NVRAM lock stages or invalidates the cache.

Reads are registered. The byte appears on the read data output one cycle after the read strobe and stays there until the next read. Any address the block does not decode returns all ones. A write to such an address changes nothing.

Top module: `sysreg_bank`

## Requirements
- R1: While the active-low synchronous reset is applied, every sticky bit, every pulse output and the read data register go to zero. The map mode therefore resets to contiguous (0) and the byte order to big-endian (0).
- R2: A write to port 0x0092 copies data bit 1 to `littleEndian`. When data bit 0 is 1, the same write raises `softResetPulse`. A read of port 0x0092 returns 0x00.
- R3: A write to port 0x0808 copies data bit 0 to `diskLight`. A read of 0x0808 returns 0xFF.
- R4: A write to port 0x081C stores data bits 3:0 in `sysCtl`. A read of 0x081C returns that value with bits 7:4 zero.
- R5: A write to port 0x0850 copies data bit 0 to `mapSparse`. A read of 0x0850 returns 0x00 or 0x01 to match it.
- R6: Reads of these ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00 and 0x0823→0x03.
- R7: Writes to 0x0800, 0x0802 and 0x0803 have no effect. Their read values and all outputs stay unchanged.
- R8: Three writes each raise one pulse output: 0x0810 raises `lockTog1Pulse`, 0x0812 raises `lockTog2Pulse` and 0x0814 raises `cacheInvPulse`. Every pulse output, including `softResetPulse`, is high for exactly the one cycle that follows the write strobe.
- R9: A read of any address that R2 to R6 do not list returns 0xFF. This covers 0x0812, 0x0814 and every address whose upper bits are not all zero.
- R10: `rdData` takes its new value in the cycle after `rdEn` and holds it until the next `rdEn`.
- R11: A write to an address that R2 to R8 do not list changes no sticky bit and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 16 | Port address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| littleEndian | output | 1 | Byte-order mode, 1 = little-endian |
| diskLight | output | 1 | Disk activity light state |
| sysCtl | output | 4 | System control field |
| mapSparse | output | 1 | I/O map mode, 1 = non-contiguous |
| softResetPulse | output | 1 | One-cycle soft reset request |
| lockTog1Pulse | output | 1 | One-cycle NVRAM lock toggle, stage 1 |
| lockTog2Pulse | output | 1 | One-cycle NVRAM lock toggle, stage 2 |
| cacheInvPulse | output | 1 | One-cycle cache invalidate |

## Verification
The bench reads every address from 0x000 to 0xFFF, plus a few addresses with high bits set. It writes all ones and then all zeros to the same range, and it sweeps every data byte through the control field and the byte-order port.

- Decode that ignores the upper address bits would alias 0x1092 onto the byte-order port and fail the 0xFF expectation there.
- Read-only ports that accepted writes would change the bytes the bench reads back after the all-ones pass.
- A control field that kept more than 4 bits would read back nonzero upper bits.
- A pulse held for two cycles, or fired from a write to 0x0812's read neighbour, would show up in the cycle-by-cycle pulse checks.
- Treating 0x0814 as a readable port would break its 0xFF read while its invalidate pulse still fires.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam logic [15:0] PORT_SPECIAL = 16'h0092;
  localparam logic [15:0] PORT_CPUCFG  = 16'h0800;
  localparam logic [15:0] PORT_FEAT    = 16'h0802;
  localparam logic [15:0] PORT_STAT    = 16'h0803;
  localparam logic [15:0] PORT_LIGHT   = 16'h0808;
  localparam logic [15:0] PORT_EQUIP   = 16'h080C;
  localparam logic [15:0] PORT_LOCK1   = 16'h0810;
  localparam logic [15:0] PORT_LOCK2   = 16'h0812;
  localparam logic [15:0] PORT_INVAL   = 16'h0814;
  localparam logic [15:0] PORT_KEY     = 16'h0818;
  localparam logic [15:0] PORT_CTL     = 16'h081C;
  localparam logic [15:0] PORT_CACHEID = 16'h0823;
  localparam logic [15:0] PORT_MAP     = 16'h0850;

  localparam logic [7:0] VAL_CPUCFG  = 8'hEF;
  localparam logic [7:0] VAL_FEAT    = 8'hAD;
  localparam logic [7:0] VAL_STAT    = 8'hE0;
  localparam logic [7:0] VAL_EQUIP   = 8'h3C;
  localparam logic [7:0] VAL_EXTFEAT = 8'h39;
  localparam logic [7:0] VAL_CACHEID = 8'h03;

  typedef enum logic [3:0] {
    RS_ONES,
    RS_ZERO,
    RS_CTL,
    RS_MAP,
    RS_CPUCFG,
    RS_FEAT,
    RS_STAT,
    RS_EQUIP,
    RS_EXTFEAT,
    RS_CACHEID
  } rdSel_e;

  typedef struct packed {
    logic   wrSpecial;
    logic   wrLight;
    logic   wrCtl;
    logic   wrMap;
    logic   wrLock1;
    logic   wrLock2;
    logic   wrInv;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          stb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] p);
    return a == ADDR_W'(p);
  endfunction

  always_comb begin
    stb.wrSpecial = wrEn & hit(portAddr, PORT_SPECIAL);
    stb.wrLight   = wrEn & hit(portAddr, PORT_LIGHT);
    stb.wrCtl     = wrEn & hit(portAddr, PORT_CTL);
    stb.wrMap     = wrEn & hit(portAddr, PORT_MAP);
    stb.wrLock1   = wrEn & hit(portAddr, PORT_LOCK1);
    stb.wrLock2   = wrEn & hit(portAddr, PORT_LOCK2);
    stb.wrInv     = wrEn & hit(portAddr, PORT_INVAL);
    stb.rdLoad    = rdEn;
    if      (hit(portAddr, PORT_SPECIAL)) stb.rdSel = RS_ZERO;
    else if (hit(portAddr, PORT_CPUCFG))  stb.rdSel = RS_CPUCFG;
    else if (hit(portAddr, PORT_FEAT))    stb.rdSel = RS_FEAT;
    else if (hit(portAddr, PORT_STAT))    stb.rdSel = RS_STAT;
    else if (hit(portAddr, PORT_EQUIP))   stb.rdSel = RS_EQUIP;
    else if (hit(portAddr, PORT_LOCK1))   stb.rdSel = RS_EXTFEAT;
    else if (hit(portAddr, PORT_KEY))     stb.rdSel = RS_ZERO;
    else if (hit(portAddr, PORT_CTL))     stb.rdSel = RS_CTL;
    else if (hit(portAddr, PORT_CACHEID)) stb.rdSel = RS_CACHEID;
    else if (hit(portAddr, PORT_MAP))     stb.rdSel = RS_MAP;
    else                                  stb.rdSel = RS_ONES;
  end

endmodule

// File: rtl/sysreg_dpath.sv
module sysreg_dpath
  import sysreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              littleEndian,
  output logic              diskLight,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              mapSparse,
  output logic              softResetPulse,
  output logic              lockTog1Pulse,
  output logic              lockTog2Pulse,
  output logic              cacheInvPulse
);

  logic [DATA_W-1:0] rdNext;
  logic              unusedWrData;

  assign unusedWrData = ^wrData[DATA_W-1:CTL_W];

  always_comb begin
    case (stb.rdSel)
      RS_ZERO:    rdNext = '0;
      RS_CTL:     rdNext = DATA_W'(sysCtl);
      RS_MAP:     rdNext = DATA_W'(mapSparse);
      RS_CPUCFG:  rdNext = DATA_W'(VAL_CPUCFG);
      RS_FEAT:    rdNext = DATA_W'(VAL_FEAT);
      RS_STAT:    rdNext = DATA_W'(VAL_STAT);
      RS_EQUIP:   rdNext = DATA_W'(VAL_EQUIP);
      RS_EXTFEAT: rdNext = DATA_W'(VAL_EXTFEAT);
      RS_CACHEID: rdNext = DATA_W'(VAL_CACHEID);
      default:    rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      littleEndian   <= 1'b0;
      diskLight      <= 1'b0;
      sysCtl         <= '0;
      mapSparse      <= 1'b0;
      softResetPulse <= 1'b0;
      lockTog1Pulse  <= 1'b0;
      lockTog2Pulse  <= 1'b0;
      cacheInvPulse  <= 1'b0;
      rdData         <= '0;
    end else begin
      if (stb.wrSpecial) littleEndian <= wrData[1];
      if (stb.wrLight)   diskLight    <= wrData[0];
      if (stb.wrCtl)     sysCtl       <= wrData[CTL_W-1:0];
      if (stb.wrMap)     mapSparse    <= wrData[0];
      softResetPulse <= stb.wrSpecial & wrData[0];
      lockTog1Pulse  <= stb.wrLock1;
      lockTog2Pulse  <= stb.wrLock2;
      cacheInvPulse  <= stb.wrInv;
      if (stb.rdLoad) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              littleEndian,
  output logic              diskLight,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              mapSparse,
  output logic              softResetPulse,
  output logic              lockTog1Pulse,
  output logic              lockTog2Pulse,
  output logic              cacheInvPulse
);

  strobes_t stb;

  sysreg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .portAddr (portAddr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .stb      (stb)
  );

  sysreg_dpath #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wrData         (wrData),
    .rdData         (rdData),
    .littleEndian   (littleEndian),
    .diskLight      (diskLight),
    .sysCtl         (sysCtl),
    .mapSparse      (mapSparse),
    .softResetPulse (softResetPulse),
    .lockTog1Pulse  (lockTog1Pulse),
    .lockTog2Pulse  (lockTog2Pulse),
    .cacheInvPulse  (cacheInvPulse)
  );

endmodule

// File: rtl/sysreg_bank_checker.sv
module sysreg_bank_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] portAddr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              littleEndian,
  input logic              diskLight,
  input logic              mapSparse,
  input logic              softResetPulse,
  input logic              lockTog1Pulse,
  input logic              lockTog2Pulse,
  input logic              cacheInvPulse
);

  AST_SOFTRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |=> !softResetPulse); // R2
  AST_ENDIAN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0092)) |=> $stable(littleEndian)); // R2
  AST_LIGHT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0808)) |=> $stable(diskLight)); // R3
  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && portAddr == ADDR_W'(16'h081C)) |=> (rdData[DATA_W-1:4] == '0)); // R4
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0850)) |=> $stable(mapSparse)); // R5
  AST_PULSES_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({softResetPulse, lockTog1Pulse, lockTog2Pulse, cacheInvPulse})); // R8
  AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0810)) |=> !lockTog1Pulse); // R8
  AST_LOCK2_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0812)) |=> !lockTog2Pulse); // R8
  AST_INV_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portAddr == ADDR_W'(16'h0814)) |=> !cacheInvPulse); // R8
  AST_RDDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R10

endmodule

bind sysreg_bank sysreg_bank_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .portAddr       (portAddr),
  .wrEn           (wrEn),
  .rdEn           (rdEn),
  .rdData         (rdData),
  .littleEndian   (littleEndian),
  .diskLight      (diskLight),
  .mapSparse      (mapSparse),
  .softResetPulse (softResetPulse),
  .lockTog1Pulse  (lockTog1Pulse),
  .lockTog2Pulse  (lockTog2Pulse),
  .cacheInvPulse  (cacheInvPulse)
);

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] portAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        littleEndian, diskLight, mapSparse;
  logic [3:0]  sysCtl;
  logic        softResetPulse, lockTog1Pulse, lockTog2Pulse, cacheInvPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       mLe = 1'b0, mLight = 1'b0, mMap = 1'b0;
  logic [3:0] mCtl = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_bank u_sysreg_bank (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
    .littleEndian(littleEndian), .diskLight(diskLight), .sysCtl(sysCtl),
    .mapSparse(mapSparse), .softResetPulse(softResetPulse),
    .lockTog1Pulse(lockTog1Pulse), .lockTog2Pulse(lockTog2Pulse),
    .cacheInvPulse(cacheInvPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h081C: return {4'h0, mCtl};
      16'h0823: return 8'h03;
      16'h0850: return {7'h0, mMap};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string readTag(input logic [15:0] a);
    case (a)
      16'h0092: return "R2 read special";
      16'h081C: return "R4 read ctl";
      16'h0850: return "R5 read map";
      16'h0800, 16'h0802, 16'h0803: return "R6/R7 read-only id";
      16'h080C, 16'h0810, 16'h0818, 16'h0823: return "R6 fixed";
      default: return "R9 undecoded";
    endcase
  endfunction

  // pulse vector {cacheInv, lock2, lock1, softReset}
  function automatic logic [3:0] expPulse(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h0092: return {3'b000, d[0]};
      16'h0810: return 4'b0010;
      16'h0812: return 4'b0100;
      16'h0814: return 4'b1000;
      default:  return 4'b0000;
    endcase
  endfunction

  // called at a falling edge
  task automatic doRead(input logic [15:0] a);
    logic [7:0] e;
    e = expRead(a);
    portAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == e, readTag(a), rdData, e);
    portAddr = 16'hFFFF;
    @(negedge clk);
    check(rdData == e, "R10 read data holds", rdData, e);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] ep;
    ep = expPulse(a, d);
    case (a)
      16'h0092: mLe = d[1];
      16'h0808: mLight = d[0];
      16'h081C: mCtl = d[3:0];
      16'h0850: mMap = d[0];
      default: ;
    endcase
    portAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check({cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse} == ep,
          "R8/R11 pulses after write", {cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse}, ep);
    check({littleEndian, diskLight, sysCtl, mapSparse} == {mLe, mLight, mCtl, mMap},
          "R2/R3/R4/R5/R7/R11 sticky state", {littleEndian, diskLight, sysCtl, mapSparse},
          {mLe, mLight, mCtl, mMap});
    @(negedge clk);
    check({cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse} == 4'b0,
          "R8 pulse lasts one cycle", {cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({littleEndian, diskLight, sysCtl, mapSparse} == 0, "R1 sticky reset", {littleEndian, diskLight, sysCtl, mapSparse}, 0);
    check({cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse} == 0, "R1 pulses reset",
          {cacheInvPulse, lockTog2Pulse, lockTog1Pulse, softResetPulse}, 0);
    check(rdData == 8'h00, "R1 rdData reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // read sweep from reset: R6, R9, R2/R4/R5 defaults
    for (int a = 0; a < 4096; a++) doRead(16'(a));
    doRead(16'h1092); doRead(16'hF810); doRead(16'h881C); doRead(16'hFFFF);

    // write all ones everywhere: R2, R3, R4, R5, R7, R8, R11
    for (int a = 0; a < 4096; a++) doWrite(16'(a), 8'hFF);
    doWrite(16'h1092, 8'h00); doWrite(16'h8810, 8'hFF);
    for (int a = 0; a < 4096; a++) doRead(16'(a));

    // data sweeps
    for (int d = 0; d < 256; d++) begin
      doWrite(16'h081C, 8'(d));
      doRead(16'h081C);                       // R4
    end
    for (int d = 0; d < 256; d++) begin
      doWrite(16'h0092, 8'(d));
      doRead(16'h0092);                       // R2
    end
    for (int d = 0; d < 4; d++) begin
      doWrite(16'h0850, 8'(d)); doRead(16'h0850); // R5
      doWrite(16'h0808, 8'(d));               // R3
      doRead(16'h0808);                       // R3 reads 0xFF
    end

    // read-only writes with zero data, then confirm fixed bytes: R7
    doWrite(16'h0800, 8'h00); doWrite(16'h0802, 8'h00); doWrite(16'h0803, 8'h00);
    doRead(16'h0800); doRead(16'h0802); doRead(16'h0803);

    // clear sweep
    for (int a = 0; a < 4096; a++) doWrite(16'(a), 8'h00);
    doRead(16'h081C); doRead(16'h0850); doRead(16'h0814); doRead(16'h0812);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule